// File: doc/BRIEF.md
# Integer Execute Unit with Field Decode

This block is the combinational execute stage of a 32-bit integer core. It takes the raw opcode, funct3 and funct7 fields of the current instruction together with the two register operand values and the immediate. It returns one result word in the same cycle. There is no separate ALU control code: the unit picks the operation from the instruction fields itself.

The unit covers register-register arithmetic, logic and shifts, and three register-immediate operations. It also places an upper immediate and forms base-plus-offset addresses for loads and stores. Register file access, memory and branch comparison are handled by other blocks. When an encoding is not supported, the unit drives a zero result and raises a flag, so that the surrounding pipeline can trap on it.

Top module: `exu_core`

## Requirements
- R1: With opcode 0110011 and funct3 000, the result is rs1 + rs2 when funct7 is 0000000, and rs1 - rs2 (modulo 2^32) when funct7 is 0100000.
- R2: With opcode 0110011 and funct7 0000000, funct3 110 gives rs1 | rs2 and funct3 100 gives rs1 ^ rs2.
- R3: With opcode 0110011, funct3 001 and funct7 0000000, the result is rs1 shifted left by rs2[4:0]. The upper bits of rs2 have no effect.
- R4: With opcode 0110011 and funct3 101, the result is rs1 shifted right by rs2[4:0]. funct7 0000000 fills the vacated bits with zeros. funct7 0100000 fills them with copies of rs1[31].
- R5: With opcode 0010011, funct3 000 gives rs1 + imm, funct3 111 gives rs1 & imm and funct3 110 gives rs1 | imm, where imm is the already sign-extended immediate input. funct7 has no effect on these operations.
- R6: With opcode 0110111, the result is imm[19:0] shifted left by 12, so an immediate of 5 gives 0x00005000. rs1, rs2, funct3 and funct7 have no effect.
- R7: With opcode 0000011 and funct3 000 to 110, or opcode 0100011 and funct3 000 to 010, the result is the address rs1 + imm.
- R8: Every other combination drives result 0 and illegal 1; any supported combination drives illegal 0. The unsupported combinations include:
  - any other opcode;
  - register-register funct7 other than 0000000 and 0100000;
  - funct7 0100000 with funct3 other than 000 or 101;
  - register-register funct3 010, 011 or 111;
  - register-immediate funct3 001 to 101;
  - load funct3 111;
  - store funct3 011 to 111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 7 | Instruction bits [6:0] |
| funct3 | input | 3 | Instruction bits [14:12] |
| funct7 | input | 7 | Instruction bits [31:25] |
| rs1_val | input | 32 | First register operand |
| rs2_val | input | 32 | Second register operand |
| imm_val | input | 32 | Sign-extended immediate; for upper-immediate, the 20-bit field in the low bits |
| result | output | 32 | Operation result or computed address |
| illegal | output | 1 | High for an unsupported encoding |

## Verification
The bench builds the unit with its default 32-bit data width, which gives a five-stage shifter. At this width, shift amounts of 0, 31 and values above 31 all reach the stage edges, and sign fill from bit 31 can be observed. It also exercises operand patterns that cross the carry chain end to end: an all-ones operand plus one, and a subtraction that goes below zero. Each illegal class listed in R8 is driven with non-zero operands, so that a leaked result would be visible at the port.

// File: rtl/exu_pkg.sv
// Package: shared encodings for the execute unit.
// Assumes standard 32-bit instruction field positions are decoded upstream.
package exu_pkg;
    localparam logic [6:0] OPC_REG   = 7'b0110011;
    localparam logic [6:0] OPC_IMM   = 7'b0010011;
    localparam logic [6:0] OPC_UPPER = 7'b0110111;
    localparam logic [6:0] OPC_LOAD  = 7'b0000011;
    localparam logic [6:0] OPC_STORE = 7'b0100011;
    localparam logic [6:0] F7_BASE   = 7'b0000000;
    localparam logic [6:0] F7_ALT    = 7'b0100000;

    typedef enum logic [3:0] {
        EX_ADD, EX_SUB, EX_OR, EX_XOR, EX_AND,
        EX_SLL, EX_SRL, EX_SRA, EX_UPPER, EX_NONE
    } exu_op_e;
endpackage

// File: rtl/exu_decode.sv
// Module: exu_decode
// Maps opcode/funct3/funct7 to an internal operation and operand source.
// Assumes fields are taken straight from the instruction word.
module exu_decode
    import exu_pkg::*;
(
    input  logic [6:0] opcode,
    input  logic [2:0] funct3,
    input  logic [6:0] funct7,
    output exu_op_e    op,
    output logic       use_imm,
    output logic       bad_enc
);
    // Select the operation from the instruction fields.
    always_comb begin
        op      = EX_NONE;
        use_imm = 1'b0;
        case (opcode)
            OPC_REG: begin
                if (funct7 == F7_BASE) begin
                    case (funct3)
                        3'b000:  op = EX_ADD;
                        3'b110:  op = EX_OR;
                        3'b100:  op = EX_XOR;
                        3'b001:  op = EX_SLL;
                        3'b101:  op = EX_SRL;
                        default: op = EX_NONE;
                    endcase
                end else if (funct7 == F7_ALT) begin
                    case (funct3)
                        3'b000:  op = EX_SUB;
                        3'b101:  op = EX_SRA;
                        default: op = EX_NONE;
                    endcase
                end
            end
            OPC_IMM: begin
                use_imm = 1'b1;
                case (funct3)
                    3'b000:  op = EX_ADD;
                    3'b111:  op = EX_AND;
                    3'b110:  op = EX_OR;
                    default: op = EX_NONE;
                endcase
            end
            OPC_UPPER: begin
                use_imm = 1'b1;
                op      = EX_UPPER;
            end
            OPC_LOAD: begin
                use_imm = 1'b1;
                op      = (funct3 != 3'b111) ? EX_ADD : EX_NONE;
            end
            OPC_STORE: begin
                use_imm = 1'b1;
                op      = (funct3 <= 3'b010) ? EX_ADD : EX_NONE;
            end
            default: op = EX_NONE;
        endcase
        bad_enc = (op == EX_NONE);
    end
endmodule

// File: rtl/exu_arith.sv
// Module: exu_arith
// Adder/subtractor and bitwise logic on two operands.
// Assumes modulo-2^XLEN wrap on overflow.
module exu_arith #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] sum,
    output logic [XLEN-1:0] diff,
    output logic [XLEN-1:0] or_v,
    output logic [XLEN-1:0] xor_v,
    output logic [XLEN-1:0] and_v
);
    // Compute every arithmetic and logic candidate in parallel.
    always_comb begin
        sum   = a + b;
        diff  = a + ~b + {{(XLEN-1){1'b0}}, 1'b1};
        or_v  = a | b;
        xor_v = a ^ b;
        and_v = a & b;
    end

    // Check that the difference added back to b restores a.
    always_comb begin
        p_sub_inverse_r1: assert (diff + b == a)
            else $error("subtract result inconsistent");
    end
endmodule

// File: rtl/exu_shift.sv
// Module: exu_shift
// Logarithmic barrel shifter: left, right logical, right arithmetic.
// Assumes the amount is the low log2(XLEN) bits of the second operand.
module exu_shift #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]         din,
    input  logic [$clog2(XLEN)-1:0] amt,
    input  logic                    arith,
    output logic [XLEN-1:0]         left_q,
    output logic [XLEN-1:0]         right_q
);
    localparam int SHW = $clog2(XLEN);

    logic [XLEN-1:0] lst [SHW+1];
    logic [XLEN-1:0] rst [SHW+1];
    logic            fill;

    // Pick the fill bit for right shifts.
    always_comb fill = arith & din[XLEN-1];

    assign lst[0] = din;
    assign rst[0] = din;

    for (genvar i = 0; i < SHW; i++) begin : g_stage
        localparam int STEP = 1 << i;
        // One power-of-two stage of each shift chain.
        always_comb begin
            lst[i+1] = amt[i] ? {lst[i][XLEN-1-STEP:0], {STEP{1'b0}}} : lst[i];
            rst[i+1] = amt[i] ? {{STEP{fill}}, rst[i][XLEN-1:STEP]} : rst[i];
        end
    end

    assign left_q  = lst[SHW];
    assign right_q = rst[SHW];

    // Check the sign fill of an arithmetic right shift and zero fill of a logical one.
    always_comb begin
        if (arith && din[XLEN-1]) begin
            p_sign_fill_r4: assert (right_q[XLEN-1])
                else $error("arithmetic shift lost sign");
        end
        if (!arith && amt != '0) begin
            p_zero_fill_r4: assert (!right_q[XLEN-1])
                else $error("logical shift filled non-zero");
        end
    end
endmodule

// File: rtl/exu_core.sv
// Module: exu_core (top)
// Combinational execute unit: decode, operand select, compute, result mux.
// Assumes a valid instruction every cycle; no internal state.
module exu_core
    import exu_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int UPPER_W = 20
) (
    input  logic [6:0]      opcode,
    input  logic [2:0]      funct3,
    input  logic [6:0]      funct7,
    input  logic [XLEN-1:0] rs1_val,
    input  logic [XLEN-1:0] rs2_val,
    input  logic [XLEN-1:0] imm_val,
    output logic [XLEN-1:0] result,
    output logic            illegal
);
    localparam int SHW    = $clog2(XLEN);
    localparam int LOW_W  = XLEN - UPPER_W;

    exu_op_e         op;
    logic            use_imm;
    logic            bad_enc;
    logic [XLEN-1:0] opnd_b;
    logic [XLEN-1:0] sum, diff, or_v, xor_v, and_v;
    logic [XLEN-1:0] left_q, right_q;
    logic [XLEN-1:0] upper_v;

    exu_decode u_dec (
        .opcode (opcode),
        .funct3 (funct3),
        .funct7 (funct7),
        .op     (op),
        .use_imm(use_imm),
        .bad_enc(bad_enc)
    );

    // Choose the second operand.
    always_comb opnd_b = use_imm ? imm_val : rs2_val;

    exu_arith #(.XLEN(XLEN)) u_arith (
        .a    (rs1_val),
        .b    (opnd_b),
        .sum  (sum),
        .diff (diff),
        .or_v (or_v),
        .xor_v(xor_v),
        .and_v(and_v)
    );

    exu_shift #(.XLEN(XLEN)) u_shift (
        .din    (rs1_val),
        .amt    (rs2_val[SHW-1:0]),
        .arith  (op == EX_SRA),
        .left_q (left_q),
        .right_q(right_q)
    );

    // Place the upper immediate field.
    always_comb upper_v = {imm_val[UPPER_W-1:0], {LOW_W{1'b0}}};

    // Final result selection; unsupported encodings give zero.
    always_comb begin
        case (op)
            EX_ADD:   result = sum;
            EX_SUB:   result = diff;
            EX_OR:    result = or_v;
            EX_XOR:   result = xor_v;
            EX_AND:   result = and_v;
            EX_SLL:   result = left_q;
            EX_SRL,
            EX_SRA:   result = right_q;
            EX_UPPER: result = upper_v;
            default:  result = '0;
        endcase
        illegal = bad_enc;
    end

    // Port-level checks on the flag and on upper-immediate placement.
    always_comb begin
        if (illegal) begin
            p_illegal_zero_r8: assert (result == '0)
                else $error("illegal op leaked a result");
        end
        if (opcode == OPC_UPPER) begin
            p_upper_low_zero_r6: assert (result[LOW_W-1:0] == '0 && !illegal)
                else $error("upper immediate misplaced");
        end
    end
endmodule

// File: tb/exu_core_tb_top.sv
// Directed bench for exu_core; one task per scenario.
module exu_core_tb_top;
    localparam logic [6:0] RR = 7'b0110011, RI = 7'b0010011, UP = 7'b0110111;
    localparam logic [6:0] LD = 7'b0000011, ST = 7'b0100011;
    localparam logic [6:0] F0 = 7'b0000000, F1 = 7'b0100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  opcode = '0;
    logic [2:0]  funct3 = '0;
    logic [6:0]  funct7 = '0;
    logic [31:0] rs1_val = '0, rs2_val = '0, imm_val = '0;
    logic [31:0] result;
    logic        illegal;
    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    exu_core dut_i (
        .opcode(opcode), .funct3(funct3), .funct7(funct7),
        .rs1_val(rs1_val), .rs2_val(rs2_val), .imm_val(imm_val),
        .result(result), .illegal(illegal)
    );

    task automatic drive(input logic [6:0] o, input logic [2:0] f3, input logic [6:0] f7,
                         input logic [31:0] a, input logic [31:0] b, input logic [31:0] im);
        @(negedge clk);
        opcode = o; funct3 = f3; funct7 = f7;
        rs1_val = a; rs2_val = b; imm_val = im;
        #1;
    endtask

    task automatic expect_val(input string req, input logic [31:0] exp_r, input logic exp_i);
        checks++;
        if (result !== exp_r || illegal !== exp_i) begin
            failures++;
            $display("FAIL %s: result=%h illegal=%b expected result=%h illegal=%b",
                     req, result, illegal, exp_r, exp_i);
        end
    endtask

    task automatic t_reset_state();
        @(negedge clk); #1;
        expect_val("R8 idle zero opcode", 32'h0, 1'b1);
    endtask

    task automatic t_add_sub_r1();
        drive(RR, 3'b000, F0, 32'h0000_0007, 32'h0000_0005, 32'h0);
        expect_val("R1 add", 32'h0000_000C, 1'b0);
        drive(RR, 3'b000, F0, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0);
        expect_val("R1 add wrap", 32'h0, 1'b0);
        drive(RR, 3'b000, F1, 32'h0000_0003, 32'h0000_0005, 32'h0);
        expect_val("R1 sub negative", 32'hFFFF_FFFE, 1'b0);
    endtask

    task automatic t_logic_r2();
        drive(RR, 3'b110, F0, 32'hF0F0_0000, 32'h0F0F_00FF, 32'h0);
        expect_val("R2 or", 32'hFFFF_00FF, 1'b0);
        drive(RR, 3'b100, F0, 32'hFFFF_0000, 32'hFF00_FF00, 32'h0);
        expect_val("R2 xor", 32'h00FF_FF00, 1'b0);
    endtask

    task automatic t_sll_r3();
        drive(RR, 3'b001, F0, 32'h0000_0001, 32'h0000_0021, 32'h0);
        expect_val("R3 sll amount masked", 32'h0000_0002, 1'b0);
        drive(RR, 3'b001, F0, 32'h0000_0001, 32'h0000_001F, 32'h0);
        expect_val("R3 sll by 31", 32'h8000_0000, 1'b0);
    endtask

    task automatic t_right_r4();
        drive(RR, 3'b101, F0, 32'h8000_0000, 32'h0000_0004, 32'h0);
        expect_val("R4 srl zero fill", 32'h0800_0000, 1'b0);
        drive(RR, 3'b101, F1, 32'h8000_0000, 32'h0000_0004, 32'h0);
        expect_val("R4 sra sign fill", 32'hF800_0000, 1'b0);
        drive(RR, 3'b101, F1, 32'h4000_0000, 32'h0000_0004, 32'h0);
        expect_val("R4 sra positive", 32'h0400_0000, 1'b0);
        drive(RR, 3'b101, F1, 32'h8765_4321, 32'h0000_0000, 32'h0);
        expect_val("R4 sra by 0", 32'h8765_4321, 1'b0);
    endtask

    task automatic t_imm_r5();
        drive(RI, 3'b000, 7'h55, 32'h0000_0005, 32'hDEAD_BEEF, 32'h0000_0005);
        expect_val("R5 addi", 32'h0000_000A, 1'b0);
        drive(RI, 3'b111, F0, 32'h1234_5678, 32'h0, 32'hFFFF_FF0F);
        expect_val("R5 andi", 32'h1234_5608, 1'b0);
        drive(RI, 3'b110, F0, 32'h1200_0000, 32'h0, 32'hFFFF_F800);
        expect_val("R5 ori", 32'hFFFF_F800, 1'b0);
    endtask

    task automatic t_upper_r6();
        drive(UP, 3'b111, 7'h7F, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0005);
        expect_val("R6 upper 5", 32'h0000_5000, 1'b0);
        drive(UP, 3'b000, F0, 32'h0, 32'h0, 32'h000B_EEF1);
        expect_val("R6 upper beef1", 32'hBEEF_1000, 1'b0);
        drive(RI, 3'b000, F0, 32'hBEEF_1000, 32'h0, 32'h0000_0234);
        expect_val("R6 upper then addi", 32'hBEEF_1234, 1'b0);
    endtask

    task automatic t_addr_r7();
        drive(LD, 3'b010, F0, 32'h0000_1000, 32'h0, 32'hFFFF_FFFC);
        expect_val("R7 load negative offset", 32'h0000_0FFC, 1'b0);
        drive(LD, 3'b110, F0, 32'h0000_0010, 32'h0, 32'h0000_0004);
        expect_val("R7 load funct3 110", 32'h0000_0014, 1'b0);
        drive(ST, 3'b010, F0, 32'h0000_0005, 32'h1111_1111, 32'h0000_0080);
        expect_val("R7 store word", 32'h0000_0085, 1'b0);
    endtask

    task automatic t_illegal_r8();
        drive(7'b1111111, 3'b000, F0, 32'h1, 32'h2, 32'h3);
        expect_val("R8 unknown opcode", 32'h0, 1'b1);
        drive(RR, 3'b000, 7'b0000001, 32'h1, 32'h2, 32'h3);
        expect_val("R8 bad funct7", 32'h0, 1'b1);
        drive(RR, 3'b110, F1, 32'h1, 32'h2, 32'h3);
        expect_val("R8 alt funct7 on or", 32'h0, 1'b1);
        drive(RR, 3'b111, F0, 32'h1, 32'h2, 32'h3);
        expect_val("R8 reg funct3 111", 32'h0, 1'b1);
        drive(RI, 3'b001, F0, 32'h1, 32'h2, 32'h3);
        expect_val("R8 imm funct3 001", 32'h0, 1'b1);
        drive(LD, 3'b111, F0, 32'h1, 32'h2, 32'h3);
        expect_val("R8 load funct3 111", 32'h0, 1'b1);
        drive(ST, 3'b011, F0, 32'h1, 32'h2, 32'h3);
        expect_val("R8 store funct3 011", 32'h0, 1'b1);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_add_sub_r1();
        t_logic_r2();
        t_sll_r3();
        t_right_r4();
        t_imm_r5();
        t_upper_r6();
        t_addr_r7();
        t_illegal_r8();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (10000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog: expired, expected completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule